// File: doc/BRIEF.md
# Input Glitch Filter

This block cleans up slow, noisy control inputs (end-of-travel switches, slow-down inputs, a home switch, alarm and in-position lines) before the rest of a motion controller uses them. A raw input is first brought into the clock domain by a two-flop synchronizer. A persistence filter then lets a new level through only after that level has been seen on every clock for a full time constant. A 2-bit code selects one of four time constants, which run from microseconds to milliseconds at the 20 MHz reference clock. Any shorter pulse never shows up at the output.

A second lane serves encoder phase and index lines. It uses the same persistence filter with a short fixed window of 3 clocks. Each lane has its own enable. When a lane's filter is off, its output is a registered copy of the synchronized input.

Top module: `input_deglitch`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `slow_out` and `enc_out` are 0.
- R2: With a lane's enable at 0, its output shows the raw level sampled at a rising edge two rising edges later, whatever the pulse width.
- R3: With `slow_en` at 1, the slow lane needs a new raw level held for N consecutive sampling edges before it passes. A level held for N-1 edges is rejected. N depends on `tc_sel`: 2'b00 gives 64, 2'b01 gives 500, 2'b10 gives 4000 and 2'b11 gives 32000.
- R4: A return of the synchronized input to the current output level restarts the count. Separate stretches of a new level never add up.
- R5: A change of `tc_sel` restarts the slow lane's count, and the new code's N applies from that point.
- R6: With `enc_en` at 1, the encoder lane accepts a level held for 3 sampling edges and rejects one held for 1 or 2.
- R7: The two enables are independent. Each lane filters or bypasses according to its own enable only.
- R8: The persistence counter never reaches the selected N, so it fits 15 bits for every code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_raw | input | 1 | Raw slow control input |
| slow_en | input | 1 | Enable for the slow-lane persistence filter |
| tc_sel | input | 2 | Slow-lane time-constant code |
| enc_raw | input | 1 | Raw encoder phase or index input |
| enc_en | input | 1 | Enable for the encoder-lane 3-clock filter |
| slow_out | output | 1 | Filtered slow input |
| enc_out | output | 1 | Filtered encoder input |

## Verification
The hardest case to reach is the edge of the longest window. A pulse of 31999 clocks must vanish and one of 32000 clocks must pass, so the stimulus holds the raw line for those exact lengths and then waits a full window for the output to fall back. A close second is a code change part-way through a count. The bench raises the input under the shortest code, switches to the 500-clock code after 40 clocks, and checks that the output is still low at a point where the old code would already have let the level through.

// File: rtl/deglitch_pkg.sv
package deglitch_pkg;

  typedef enum logic [1:0] {
    TC_SHORT = 2'b00,
    TC_MID   = 2'b01,
    TC_LONG  = 2'b10,
    TC_XLONG = 2'b11
  } tc_code_e;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stage_q;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= 1'b0;
          else     stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[i] <= 1'b0;
          else     stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/tc_select.sv
module tc_select
  import deglitch_pkg::*;
#(
  parameter int          CNT_W   = 15,
  parameter int unsigned TC_CYC0 = 64,
  parameter int unsigned TC_CYC1 = 500,
  parameter int unsigned TC_CYC2 = 4000,
  parameter int unsigned TC_CYC3 = 32000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] limit,
  output logic             restart
);

  tc_code_e         sel_q;
  logic [CNT_W-1:0] limit_d;
  logic [CNT_W-1:0] limit_q;

  always_comb begin
    case (tc_code_e'(sel))
      TC_SHORT: limit_d = CNT_W'(TC_CYC0);
      TC_MID:   limit_d = CNT_W'(TC_CYC1);
      TC_LONG:  limit_d = CNT_W'(TC_CYC2);
      default:  limit_d = CNT_W'(TC_CYC3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= TC_SHORT;
      limit_q <= CNT_W'(TC_CYC0);
    end else begin
      sel_q   <= tc_code_e'(sel);
      limit_q <= limit_d;
    end
  end

  assign limit   = limit_q;
  assign restart = (tc_code_e'(sel) != sel_q);

endmodule

// File: rtl/persist_filter.sv
module persist_filter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             din,
  input  logic [CNT_W-1:0] limit,
  input  logic             restart,
  output logic             dout
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      out_q <= din;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (din == out_q) begin
      cnt_q <= '0;
    end else if (cnt_q == limit - ONE) begin
      cnt_q <= '0;
      out_q <= din;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign dout = out_q;

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < limit);

  // R3
  persist_only_chk: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$past(restart) && (out_q != $past(out_q)))
      |-> ($past(cnt_q) == $past(limit) - ONE));

  // R2
  bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (out_q == $past(din)));

  // R5
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (en && restart) |=> (cnt_q == '0));

endmodule

// File: rtl/input_deglitch.sv
module input_deglitch #(
  parameter int          SYNC_STAGES = 2,
  parameter int          CNT_W       = 15,
  parameter int unsigned TC_CYC0     = 64,
  parameter int unsigned TC_CYC1     = 500,
  parameter int unsigned TC_CYC2     = 4000,
  parameter int unsigned TC_CYC3     = 32000,
  parameter int unsigned ENC_CYC     = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slow_raw,
  input  logic       slow_en,
  input  logic [1:0] tc_sel,
  input  logic       enc_raw,
  input  logic       enc_en,
  output logic       slow_out,
  output logic       enc_out
);

  localparam logic [CNT_W-1:0] ENC_LIMIT = CNT_W'(ENC_CYC);

  logic             slow_s;
  logic             enc_s;
  logic [CNT_W-1:0] slow_limit;
  logic             slow_restart;

  pin_sync #(.STAGES(SYNC_STAGES)) u_slow_sync (
    .clk(clk), .rst(rst), .d(slow_raw), .q(slow_s)
  );

  pin_sync #(.STAGES(SYNC_STAGES)) u_enc_sync (
    .clk(clk), .rst(rst), .d(enc_raw), .q(enc_s)
  );

  tc_select #(
    .CNT_W(CNT_W), .TC_CYC0(TC_CYC0), .TC_CYC1(TC_CYC1),
    .TC_CYC2(TC_CYC2), .TC_CYC3(TC_CYC3)
  ) u_tc (
    .clk(clk), .rst(rst), .sel(tc_sel),
    .limit(slow_limit), .restart(slow_restart)
  );

  persist_filter #(.CNT_W(CNT_W)) u_slow_filt (
    .clk(clk), .rst(rst), .en(slow_en), .din(slow_s),
    .limit(slow_limit), .restart(slow_restart), .dout(slow_out)
  );

  persist_filter #(.CNT_W(CNT_W)) u_enc_filt (
    .clk(clk), .rst(rst), .en(enc_en), .din(enc_s),
    .limit(ENC_LIMIT), .restart(1'b0), .dout(enc_out)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk)
    rst |=> (!slow_out && !enc_out));

endmodule

// File: tb/input_deglitch_bench.sv
module input_deglitch_bench;

  localparam int N0 = 64, N1 = 500, N2 = 4000, N3 = 32000, NE = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slow_raw = 1'b0, slow_en = 1'b0, enc_raw = 1'b0, enc_en = 1'b0;
  logic [1:0] tc_sel = 2'b00;
  logic       slow_out, enc_out;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";
  bit slow_seen = 0, enc_seen = 0;

  always #10 clk = ~clk;

  input_deglitch u_input_deglitch (
    .clk(clk), .rst(rst), .slow_raw(slow_raw), .slow_en(slow_en),
    .tc_sel(tc_sel), .enc_raw(enc_raw), .enc_en(enc_en),
    .slow_out(slow_out), .enc_out(enc_out)
  );

  // behavioural reference model
  int m_s1, m_s2, m_so, m_sc, m_e1, m_e2, m_eo, m_ec, m_psel;

  function automatic int lim(input logic [1:0] c);
    case (c)
      2'b00: return N0;
      2'b01: return N1;
      2'b10: return N2;
      default: return N3;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_so = 0; m_sc = 0;
      m_e1 = 0; m_e2 = 0; m_eo = 0; m_ec = 0; m_psel = 0;
    end else begin
      if (!slow_en) begin m_so = m_s2; m_sc = 0; end
      else if (int'(tc_sel) != m_psel) m_sc = 0;
      else if (m_s2 == m_so) m_sc = 0;
      else if (m_sc == lim(tc_sel) - 1) begin m_so = m_s2; m_sc = 0; end
      else m_sc++;
      if (!enc_en) begin m_eo = m_e2; m_ec = 0; end
      else if (m_e2 == m_eo) m_ec = 0;
      else if (m_ec == NE - 1) begin m_eo = m_e2; m_ec = 0; end
      else m_ec++;
      m_s2 = m_s1; m_s1 = int'(slow_raw);
      m_e2 = m_e1; m_e1 = int'(enc_raw);
      m_psel = int'(tc_sel);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(int'(slow_out) == m_so, {cur_req, " slow_out"}, int'(slow_out), m_so);
      check(int'(enc_out) == m_eo, {cur_req, " enc_out"}, int'(enc_out), m_eo);
    end
    if (slow_out) slow_seen = 1;
    if (enc_out) enc_seen = 1;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive a slow pulse of w sampled edges; expect it to pass when w >= n
  task automatic slow_pulse(input int w, input int n, input string req);
    bit acc;
    acc = (w >= n);
    @(negedge clk);
    slow_seen = 0;
    slow_raw = 1'b1;
    cyc(w);
    slow_raw = 1'b0;
    cyc(acc ? n + 8 : 8);
    check(slow_seen == acc, req, int'(slow_seen), int'(acc));
    check(slow_out == 1'b0, req, int'(slow_out), 0);
  endtask

  task automatic enc_pulse(input int w, input bit acc, input string req);
    @(negedge clk);
    enc_seen = 0;
    enc_raw = 1'b1;
    cyc(w);
    enc_raw = 1'b0;
    cyc(12);
    check(enc_seen == acc, req, int'(enc_seen), int'(acc));
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(2);
    // R1: reset state
    check(slow_out == 1'b0, "R1", int'(slow_out), 0);
    check(enc_out == 1'b0, "R1", int'(enc_out), 0);
    cyc(2);
    rst = 1'b0;
    cyc(2);

    // R2: bypass latency on the slow lane
    cur_req = "R2";
    slow_raw = 1'b1;
    cyc(1); check(slow_out == 1'b0, "R2 edge0", int'(slow_out), 0);
    cyc(1); check(slow_out == 1'b0, "R2 edge1", int'(slow_out), 0);
    cyc(1); check(slow_out == 1'b1, "R2 edge2", int'(slow_out), 1);
    slow_raw = 1'b0;
    cyc(5);
    slow_pulse(1, 1, "R2 short pulse bypassed");

    // R3: each code's boundary
    slow_en = 1'b1;
    cur_req = "R3";
    tc_sel = 2'b00; cyc(3);
    slow_pulse(N0 - 1, N0, "R3 code00 reject");
    slow_pulse(N0, N0, "R3 code00 accept");
    tc_sel = 2'b01; cyc(3);
    slow_pulse(N1 - 1, N1, "R3 code01 reject");
    slow_pulse(N1, N1, "R3 code01 accept");
    tc_sel = 2'b10; cyc(3);
    slow_pulse(N2 - 1, N2, "R3 code10 reject");
    slow_pulse(N2, N2, "R3 code10 accept");
    tc_sel = 2'b11; cyc(3);
    slow_pulse(N3 - 1, N3, "R3 code11 reject");
    slow_pulse(N3, N3, "R3 code11 accept");

    // R4: interrupted level does not accumulate
    cur_req = "R4";
    tc_sel = 2'b00; cyc(3);
    slow_seen = 0;
    slow_raw = 1'b1; cyc(40);
    slow_raw = 1'b0; cyc(2);
    slow_raw = 1'b1; cyc(40);
    slow_raw = 1'b0; cyc(10);
    check(slow_seen == 1'b0, "R4 split pulse", int'(slow_seen), 0);

    // R5: code change restarts the count
    cur_req = "R5";
    slow_raw = 1'b1; cyc(40);
    tc_sel = 2'b01;
    cyc(100);
    check(slow_out == 1'b0, "R5 held after switch", int'(slow_out), 0);
    cyc(500);
    check(slow_out == 1'b1, "R5 new window", int'(slow_out), 1);
    slow_raw = 1'b0; cyc(510);
    check(slow_out == 1'b0, "R5 fall", int'(slow_out), 0);
    tc_sel = 2'b00; cyc(5);

    // R6: encoder lane fixed window
    cur_req = "R6";
    enc_en = 1'b1; cyc(3);
    enc_pulse(1, 1'b0, "R6 width1");
    enc_pulse(2, 1'b0, "R6 width2");
    enc_pulse(3, 1'b1, "R6 width3");

    // R7: independent enables
    cur_req = "R7";
    slow_en = 1'b0; enc_en = 1'b1; cyc(3);
    @(negedge clk);
    slow_seen = 0; enc_seen = 0;
    slow_raw = 1'b1; enc_raw = 1'b1;
    cyc(1);
    slow_raw = 1'b0; enc_raw = 1'b0;
    cyc(10);
    check(slow_seen == 1'b1, "R7 slow bypassed", int'(slow_seen), 1);
    check(enc_seen == 1'b0, "R7 enc filtered", int'(enc_seen), 0);
    slow_en = 1'b1; enc_en = 1'b0; cyc(3);
    @(negedge clk);
    slow_seen = 0; enc_seen = 0;
    slow_raw = 1'b1; enc_raw = 1'b1;
    cyc(1);
    slow_raw = 1'b0; enc_raw = 1'b0;
    cyc(10);
    check(slow_seen == 1'b0, "R7 slow filtered", int'(slow_seen), 0);
    check(enc_seen == 1'b1, "R7 enc bypassed", int'(enc_seen), 1);

    // R8: counter bound is covered by the code11 accept above
    cur_req = "R8";
    cyc(5);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule